// File: doc/BRIEF.md
# Flash In-System Programming Access Controller

This block sits between a processor's special-function-register (SFR) bus and an on-chip flash array. It gives firmware a way to program single bytes, read single bytes and erase the whole array. It also works out where the processor starts after reset. Firmware builds a 16-bit flash address from two byte registers and places a byte in a data register. Writing an operation code to a command register then starts one flash operation. The block checks every request against two settings. The first is a locked service-program region at the top of the address space. The second is a read-protection setting that covers the whole array.

After reset, the block first captures the lock bit, the region size N and the read-protect bit from non-volatile configuration inputs. Software cannot change them afterwards. The block then reads flash address 0. If that byte is 0xFF (blank) and the region is not empty, the reset vector is the start of the service region. Otherwise the reset vector is 0x0000. The service region covers the top N×512 bytes, so it starts at 0x10000 − N×512. Values of N above 8 are treated as 8.

Top module: `flash_isp_ctrl`

## Requirements
- R1: The flash target address is 16 bits. SFR 0xF4 holds address bits 15..8 and SFR 0xF5 holds bits 7..0. Both can be read back and both reset to 0x00.
- R2: After reset the block reads flash address 0 once and then raises `boot_done_o`. `reset_vector_o` is the region start if that byte is 0xFF and N is not 0; otherwise it is 0x0000.
- R3: The region start is 0x10000 − N×512. A configured N greater than 8 is clamped to 8.
- R4: The command code is 0x01 written to SFR 0xF7 bits 1..0. While the lock is set, a program command whose address is at or above the region start is rejected: the error flag is set and no flash request is made. A program command below the region start writes the data byte from SFR 0xF6.
- R5: Command code 0x03 requests an erase. `fl_addr_o` carries the last address to be cleared. That address is region start − 1 while the lock is set and N is not 0, and 0xFFFF otherwise.
- R6: Command code 0x02 requests a byte read. The byte returned is placed in the data register (SFR 0xF6). With read protection off, addresses inside the locked region can be read.
- R7: With read protection on, a read command is rejected: the error flag is set, no flash request is made and the data register keeps its value.
- R8: Reading SFR 0xF7 returns the status byte, with bit 7 = busy and bit 6 = error. Busy reads 1 from the cycle after an accepted command until the flash acknowledges. A command written while busy is ignored. An accepted command clears the error flag.
- R9: The lock, N and read-protect settings are captured once, right after reset. Later changes on the configuration inputs have no effect until the next reset.
- R10: With the lock clear, the region is not fenced: a program at an address inside it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data for `sfr_addr_i` (combinational) |
| cfg_lock_i | input | 1 | Non-volatile region lock |
| cfg_region_n_i | input | 4 | Non-volatile region size N, in 512-byte units |
| cfg_rd_protect_i | input | 1 | Non-volatile whole-array read protection |
| boot_done_o | output | 1 | Reset vector is valid |
| reset_vector_o | output | 16 | Initial program counter |
| fl_req_o | output | 1 | Flash request, held until acknowledged |
| fl_op_o | output | 2 | Flash operation: 1 program, 2 read, 3 erase |
| fl_addr_o | output | 16 | Flash address (for erase: last address to clear) |
| fl_wdata_o | output | 8 | Program data |
| fl_ack_i | input | 1 | Flash acknowledge |
| fl_rdata_i | input | 8 | Flash read data, valid with `fl_ack_i` |

## Verification
The assertions assume the following about the flash side. It asserts `fl_ack_i` only while a request is pending, for a single cycle, and it presents `fl_rdata_i` in that same cycle. They also assume that the configuration inputs are stable in the first clock after reset is released. The bench flash model always acknowledges one cycle after it sees a request and never acknowledges otherwise. The bench changes the configuration inputs only while reset is held, with one deliberate exception: a mid-run change that checks those inputs are ignored after capture. It waits for busy to clear before it starts the next command, except in the single test of a command written while busy.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_READ  = 2'd2,
    OP_ERASE = 2'd3
  } fpc_op_e;

  typedef enum logic [1:0] {
    ST_CFG,
    ST_BOOT,
    ST_IDLE,
    ST_BUSY
  } fpc_state_e;
endpackage

// File: rtl/fpc_region_guard.sv
module fpc_region_guard #(
  parameter int ADDR_W    = 16,
  parameter int N_W       = 4,
  parameter int N_MAX     = 8,
  parameter int SEG_SHIFT = 9
) (
  input  logic              lock_i,
  input  logic [N_W-1:0]    n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              region_en_o,
  output logic [ADDR_W-1:0] start_o,
  output logic              hit_o,
  output logic [ADDR_W-1:0] erase_last_o
);
  localparam int FW = ADDR_W + 1;
  localparam logic [FW-1:0] TOP = FW'(1) << ADDR_W;

  logic [N_W-1:0] n_eff;
  logic [FW-1:0]  span;
  logic [FW-1:0]  start_full;

  always_comb begin
    n_eff        = (n_i > N_W'(N_MAX)) ? N_W'(N_MAX) : n_i;
    span         = FW'(n_eff) << SEG_SHIFT;
    start_full   = TOP - span;
    region_en_o  = (n_eff != '0);
    start_o      = start_full[ADDR_W-1:0];
    hit_o        = lock_i && region_en_o && ({1'b0, addr_i} >= start_full);
    erase_last_o = (lock_i && region_en_o) ? (start_o - 1'b1) : '1;
  end
endmodule

// File: rtl/fpc_sfr_regs.sv
module fpc_sfr_regs
  import fpc_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter int              SFR_W  = 8,
  parameter logic [SFR_W-1:0] A_HI  = 8'hF4,
  parameter logic [SFR_W-1:0] A_LO  = 8'hF5,
  parameter logic [SFR_W-1:0] A_DAT = 8'hF6,
  parameter logic [SFR_W-1:0] A_CMD = 8'hF7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SFR_W-1:0]    sfr_addr_i,
  input  logic                sfr_wr_i,
  input  logic [DATA_W-1:0]   sfr_wdata_i,
  output logic [DATA_W-1:0]   sfr_rdata_o,
  input  logic                load_i,
  input  logic [DATA_W-1:0]   load_data_i,
  input  logic                busy_i,
  input  logic                err_i,
  output logic [2*DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                cmd_wr_o,
  output fpc_op_e             cmd_o
);
  logic [DATA_W-1:0] hi_q, lo_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      data_q <= '0;
    end else begin
      if (sfr_wr_i && sfr_addr_i == A_HI) hi_q <= sfr_wdata_i;
      if (sfr_wr_i && sfr_addr_i == A_LO) lo_q <= sfr_wdata_i;
      // flash read result wins over a same-cycle software write
      if (load_i) data_q <= load_data_i;
      else if (sfr_wr_i && sfr_addr_i == A_DAT) data_q <= sfr_wdata_i;
    end
  end

  assign addr_o   = {hi_q, lo_q};
  assign data_o   = data_q;
  assign cmd_wr_o = sfr_wr_i && (sfr_addr_i == A_CMD);
  assign cmd_o    = fpc_op_e'(sfr_wdata_i[1:0]);

  always_comb begin
    unique case (sfr_addr_i)
      A_HI:    sfr_rdata_o = hi_q;
      A_LO:    sfr_rdata_o = lo_q;
      A_DAT:   sfr_rdata_o = data_q;
      A_CMD:   sfr_rdata_o = {busy_i, err_i, (DATA_W-2)'(0)};
      default: sfr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int N_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_lock_i,
  input  logic [N_W-1:0]    cfg_n_i,
  input  logic              cfg_rdprot_i,
  output logic              lock_o,
  output logic [N_W-1:0]    n_o,
  input  logic              cmd_wr_i,
  input  fpc_op_e           cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              hit_i,
  input  logic              region_en_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] erase_last_i,
  output logic              fl_req_o,
  output fpc_op_e           fl_op_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  input  logic              fl_ack_i,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              boot_done_o,
  output logic [ADDR_W-1:0] vector_o
);
  fpc_state_e        state_q;
  fpc_op_e           op_q;
  logic [ADDR_W-1:0] op_addr_q, vector_q;
  logic [DATA_W-1:0] wdata_q;
  logic              lock_q, rdprot_q, err_q;
  logic [N_W-1:0]    n_q;
  logic              reject;

  assign reject = (cmd_i == OP_PROG && hit_i) || (cmd_i == OP_READ && rdprot_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CFG;
      op_q      <= OP_NONE;
      op_addr_q <= '0;
      wdata_q   <= '0;
      vector_q  <= '0;
      lock_q    <= 1'b0;
      rdprot_q  <= 1'b0;
      n_q       <= '0;
      err_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CFG: begin
          lock_q   <= cfg_lock_i;
          n_q      <= cfg_n_i;
          rdprot_q <= cfg_rdprot_i;
          state_q  <= ST_BOOT;
        end
        ST_BOOT: if (fl_ack_i) begin
          vector_q <= (fl_rdata_i == '1 && region_en_i) ? start_i : '0;
          state_q  <= ST_IDLE;
        end
        ST_IDLE: if (cmd_wr_i && cmd_i != OP_NONE) begin
          if (reject) begin
            err_q <= 1'b1;
          end else begin
            err_q     <= 1'b0;
            op_q      <= cmd_i;
            op_addr_q <= (cmd_i == OP_ERASE) ? erase_last_i : addr_i;
            wdata_q   <= data_i;
            state_q   <= ST_BUSY;
          end
        end
        ST_BUSY: if (fl_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_req_o  = (state_q == ST_BOOT) || (state_q == ST_BUSY);
    fl_op_o   = (state_q == ST_BOOT) ? OP_READ : op_q;
    fl_addr_o = (state_q == ST_BOOT) ? '0 : op_addr_q;
  end

  assign fl_wdata_o  = wdata_q;
  assign busy_o      = (state_q == ST_BUSY);
  assign err_o       = err_q;
  assign load_o      = (state_q == ST_BUSY) && fl_ack_i && (op_q == OP_READ);
  assign load_data_o = fl_rdata_i;
  assign boot_done_o = (state_q == ST_IDLE) || (state_q == ST_BUSY);
  assign vector_o    = vector_q;
  assign lock_o      = lock_q;
  assign n_o         = n_q;

  // R8: a pending request keeps its address and operation until acknowledged
  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !fl_ack_i) |=> (fl_req_o && $stable(fl_addr_o) && $stable(fl_op_o)));

  // R7: no read reaches the array after boot while protection is captured on
  assert_no_prot_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_done_o && fl_req_o && fl_op_o == OP_READ) |-> !rdprot_q);

  // R9: boot completes once and the captured settings stay put
  assert_boot_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |=> (boot_done_o && $stable(lock_o) && $stable(n_o) && $stable(vector_o)));
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import fpc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int N_W       = 4,
  parameter int N_MAX     = 8,
  parameter int SEG_SHIFT = 9,
  parameter int SFR_W     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SFR_W-1:0]    sfr_addr_i,
  input  logic                sfr_wr_i,
  input  logic [DATA_W-1:0]   sfr_wdata_i,
  output logic [DATA_W-1:0]   sfr_rdata_o,
  input  logic                cfg_lock_i,
  input  logic [N_W-1:0]      cfg_region_n_i,
  input  logic                cfg_rd_protect_i,
  output logic                boot_done_o,
  output logic [2*DATA_W-1:0] reset_vector_o,
  output logic                fl_req_o,
  output logic [1:0]          fl_op_o,
  output logic [2*DATA_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0]   fl_wdata_o,
  input  logic                fl_ack_i,
  input  logic [DATA_W-1:0]   fl_rdata_i
);
  localparam int ADDR_W = 2 * DATA_W;

  logic              lock, region_en, hit, cmd_wr, load, busy, err;
  logic [N_W-1:0]    n_cap;
  logic [ADDR_W-1:0] addr, start, erase_last;
  logic [DATA_W-1:0] data, load_data;
  fpc_op_e           cmd, op;

  fpc_sfr_regs #(.DATA_W(DATA_W), .SFR_W(SFR_W)) u_regs (
    .clk_i, .rst_ni, .sfr_addr_i, .sfr_wr_i, .sfr_wdata_i, .sfr_rdata_o,
    .load_i(load), .load_data_i(load_data), .busy_i(busy), .err_i(err),
    .addr_o(addr), .data_o(data), .cmd_wr_o(cmd_wr), .cmd_o(cmd)
  );

  fpc_region_guard #(.ADDR_W(ADDR_W), .N_W(N_W), .N_MAX(N_MAX), .SEG_SHIFT(SEG_SHIFT)) u_guard (
    .lock_i(lock), .n_i(n_cap), .addr_i(addr), .region_en_o(region_en),
    .start_o(start), .hit_o(hit), .erase_last_o(erase_last)
  );

  fpc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W)) u_seq (
    .clk_i, .rst_ni, .cfg_lock_i, .cfg_n_i(cfg_region_n_i), .cfg_rdprot_i(cfg_rd_protect_i),
    .lock_o(lock), .n_o(n_cap), .cmd_wr_i(cmd_wr), .cmd_i(cmd), .addr_i(addr), .data_i(data),
    .hit_i(hit), .region_en_i(region_en), .start_i(start), .erase_last_i(erase_last),
    .fl_req_o, .fl_op_o(op), .fl_addr_o, .fl_wdata_o, .fl_ack_i, .fl_rdata_i,
    .busy_o(busy), .err_o(err), .load_o(load), .load_data_o(load_data),
    .boot_done_o, .vector_o(reset_vector_o)
  );

  assign fl_op_o = op;

  // R4: a locked region never sees a program request
  assert_no_region_prog_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && op == OP_PROG) |-> !(lock && region_en && fl_addr_o >= start));

  // R5: an erase never reaches into the locked region
  assert_erase_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && op == OP_ERASE && lock && region_en) |-> (fl_addr_o < start));

  // R2: the reset vector is zero or the region start
  assert_vector_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_o |-> (reset_vector_o == '0 || (region_en && reset_vector_o == start)));
endmodule

// File: tb/flash_isp_ctrl_bench.sv
`timescale 1ns/1ps
module flash_isp_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00, sfr_rdata;
  logic        sfr_wr = 1'b0;
  logic        cfg_lock = 1'b0, cfg_rdp = 1'b0;
  logic [3:0]  cfg_n = 4'd0;
  logic        boot_done, fl_req, fl_ack;
  logic [15:0] vector, fl_addr;
  logic [1:0]  fl_op;
  logic [7:0]  fl_wdata, fl_rdata;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  flash_isp_ctrl u_flash_isp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sfr_addr_i(sfr_addr), .sfr_wr_i(sfr_wr),
    .sfr_wdata_i(sfr_wdata), .sfr_rdata_o(sfr_rdata), .cfg_lock_i(cfg_lock),
    .cfg_region_n_i(cfg_n), .cfg_rd_protect_i(cfg_rdp), .boot_done_o(boot_done),
    .reset_vector_o(vector), .fl_req_o(fl_req), .fl_op_o(fl_op), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_ack_i(fl_ack), .fl_rdata_i(fl_rdata)
  );

  // flash model: 256-byte window indexed by address low byte, ack one cycle after request
  logic [7:0]  mem [256];
  int          op_cnt = 0;
  logic [15:0] last_erase = 16'h0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_ack   <= 1'b0;
      fl_rdata <= 8'h00;
    end else begin
      fl_ack <= fl_req && !fl_ack;
      if (fl_req && !fl_ack) begin
        op_cnt <= op_cnt + 1;
        case (fl_op)
          2'd1: mem[fl_addr[7:0]] <= fl_wdata;
          2'd2: fl_rdata <= mem[fl_addr[7:0]];
          2'd3: last_erase <= fl_addr;
          default: ;
        endcase
      end
    end
  end

  // {n, byte at address 0, expected vector, lock}
  localparam logic [28:0] BOOT_TBL [7] = '{
    {4'd8,  8'hFF, 16'hF000, 1'b1},
    {4'd8,  8'h12, 16'h0000, 1'b1},
    {4'd0,  8'hFF, 16'h0000, 1'b1},
    {4'd1,  8'hFF, 16'hFE00, 1'b0},
    {4'd4,  8'hFF, 16'hF800, 1'b1},
    {4'd12, 8'hFF, 16'hF000, 1'b1},
    {4'd2,  8'hFE, 16'h0000, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1 d = sfr_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sfr_read(8'hF7, s);
      if (!s[7]) return;
    end
  endtask

  task automatic do_reset(input logic lk, input logic [3:0] n, input logic rp, input logic [7:0] b0);
    @(negedge clk);
    rst_n = 1'b0;
    mem[0] = b0;
    cfg_lock = lk; cfg_n = n; cfg_rdp = rp;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 20 && !boot_done; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int c0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'hA5);

    // table: boot vector and region start (R2, R3)
    for (int t = 0; t < 7; t++) begin
      do_reset(BOOT_TBL[t][0], BOOT_TBL[t][28:25], 1'b0, BOOT_TBL[t][24:17]);
      chk("R2 boot_done", 32'(boot_done), 32'd1);
      chk("R2 R3 reset vector", 32'(vector), 32'(BOOT_TBL[t][16:1]));
    end

    // locked, N=2 -> region start 0xFC00
    do_reset(1'b1, 4'd2, 1'b0, 8'h00);
    mem[8'h10] = 8'hC3;
    sfr_read(8'hF4, rd); chk("R1 addr hi reset", 32'(rd), 32'h00);
    sfr_read(8'hF5, rd); chk("R1 addr lo reset", 32'(rd), 32'h00);
    sfr_read(8'hF7, rd); chk("R8 status after boot", 32'(rd), 32'h00);

    sfr_write(8'hF4, 8'h12); sfr_write(8'hF5, 8'h34);
    sfr_read(8'hF4, rd); chk("R1 addr hi readback", 32'(rd), 32'h12);
    sfr_read(8'hF5, rd); chk("R1 addr lo readback", 32'(rd), 32'h34);

    sfr_write(8'hF6, 8'h5A);
    c0 = op_cnt;
    sfr_write(8'hF7, 8'h01);
    sfr_read(8'hF7, rd); chk("R8 busy after command", 32'(rd[7]), 32'd1);
    wait_idle();
    sfr_read(8'hF7, rd); chk("R4 program outside region no error", 32'(rd[6]), 32'd0);
    chk("R4 program written", 32'(mem[8'h34]), 32'h5A);
    chk("R4 one access", 32'(op_cnt - c0), 32'd1);

    sfr_write(8'hF6, 8'h00);
    sfr_write(8'hF7, 8'h02);
    wait_idle();
    sfr_read(8'hF6, rd); chk("R6 read data", 32'(rd), 32'h5A);

    sfr_write(8'hF4, 8'hFC); sfr_write(8'hF5, 8'h00); sfr_write(8'hF6, 8'h77);
    c0 = op_cnt;
    sfr_write(8'hF7, 8'h01);
    wait_idle();
    sfr_read(8'hF7, rd); chk("R4 region program error", 32'(rd), 32'h40);
    chk("R4 rejected no access", 32'(op_cnt - c0), 32'd0);
    chk("R4 array untouched", 32'(mem[8'h00]), 32'h00);

    sfr_write(8'hF4, 8'hFB); sfr_write(8'hF5, 8'hFF);
    sfr_write(8'hF7, 8'h01);
    wait_idle();
    sfr_read(8'hF7, rd); chk("R8 error cleared by accepted command", 32'(rd[6]), 32'd0);
    chk("R4 boundary below region written", 32'(mem[8'hFF]), 32'h77);

    sfr_write(8'hF7, 8'h03);
    wait_idle();
    chk("R5 locked erase limit", 32'(last_erase), 32'hFBFF);

    sfr_write(8'hF4, 8'hFC); sfr_write(8'hF5, 8'h10);
    sfr_write(8'hF7, 8'h02);
    wait_idle();
    sfr_read(8'hF6, rd); chk("R6 region readable unprotected", 32'(rd), 32'hC3);

    // R9: config changes after boot are ignored
    cfg_lock = 1'b0; cfg_n = 4'd0;
    sfr_write(8'hF4, 8'hFF); sfr_write(8'hF5, 8'h00);
    c0 = op_cnt;
    sfr_write(8'hF7, 8'h01);
    wait_idle();
    sfr_read(8'hF7, rd); chk("R9 lock still captured", 32'(rd[6]), 32'd1);
    chk("R9 no access", 32'(op_cnt - c0), 32'd0);

    // R8: second command while busy ignored
    sfr_write(8'hF4, 8'h10); sfr_write(8'hF5, 8'h20); sfr_write(8'hF6, 8'h3C);
    c0 = op_cnt;
    sfr_write(8'hF7, 8'h01);
    sfr_write(8'hF7, 8'h02);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R8 busy command ignored", 32'(op_cnt - c0), 32'd1);
    sfr_read(8'hF6, rd); chk("R8 data unchanged", 32'(rd), 32'h3C);

    // R10: lock clear leaves region open
    do_reset(1'b0, 4'd2, 1'b0, 8'h00);
    sfr_write(8'hF4, 8'hFF); sfr_write(8'hF5, 8'h40); sfr_write(8'hF6, 8'h99);
    sfr_write(8'hF7, 8'h01);
    wait_idle();
    sfr_read(8'hF7, rd); chk("R10 unlocked program accepted", 32'(rd[6]), 32'd0);
    chk("R10 unlocked region written", 32'(mem[8'h40]), 32'h99);
    sfr_write(8'hF7, 8'h03);
    wait_idle();
    chk("R5 R10 unlocked erase full", 32'(last_erase), 32'hFFFF);

    // R7: read protection
    do_reset(1'b1, 4'd2, 1'b1, 8'h00);
    sfr_write(8'hF4, 8'h12); sfr_write(8'hF5, 8'h34); sfr_write(8'hF6, 8'h11);
    c0 = op_cnt;
    sfr_write(8'hF7, 8'h02);
    wait_idle();
    sfr_read(8'hF7, rd); chk("R7 protected read error", 32'(rd[6]), 32'd1);
    chk("R7 no access", 32'(op_cnt - c0), 32'd0);
    sfr_read(8'hF6, rd); chk("R7 data kept", 32'(rd), 32'h11);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule